// File: doc/BRIEF.md
# Core Power-Up Sequencer

This block is a hardware state machine that brings a secondary processor core out of power collapse without firmware stepping through each control write. One start pulse launches a fixed walk through the power-domain controls. The walk raises the isolation clamps and holds both resets, then turns on the gated head-switch with its ramp count. It then releases the memory clamp and turns on the memory head-switch, releases the core clamp, and drops both resets. It marks the core as powered up last.

The block holds two registered words that mirror its control outputs. One is an 8-bit power control word, and the other is a 32-bit head-switch gate word that carries an enable and a ramp count. Each settle wait between steps lasts a whole number of microseconds. The wait is timed by a counter built on a parameter that gives clock cycles per microsecond. A one-cycle done pulse marks the end of the walk. Power-down sequencing is not part of the block.

Top module: `cpu_pwrup_seq`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears the control word and the gate word to all zeros, drives done and busy low, and returns the sequencer to idle.
- R2: A start sampled high while idle sets the control word to 0x33 at that edge. This means clamp (bit 0), memory clamp (bit 1), core reset (bit 4) and power-on reset (bit 5) are high and all other bits are low. The same edge clears the gate word to zero and raises busy.
- R3: One cycle after R2, the gate word becomes RAMP_COUNT in bits 31:24 with the enable in bit 0, and all other bits are zero. This is 0x1000_0001 for a ramp count of 16.
- R4: The memory clamp (bit 1) clears exactly W = CYCLES_PER_US × SETTLE_US cycles after the gate word is set, which gives 0x31. The memory head-switch (bit 3) sets on the following cycle, which gives 0x39.
- R5: The core clamp (bit 0) clears exactly W cycles after the memory head-switch turns on, which gives 0x38.
- R6: Core reset (bit 4) and power-on reset (bit 5) clear on the same edge, exactly W cycles after the core clamp release. This gives 0x08.
- R7: The powered-up bit (bit 7) sets one cycle after the resets are released, which gives 0x88. On that same cycle done is high for exactly one cycle and busy goes low.
- R8: A start that arrives while busy is ignored, and the outputs follow the same timeline as an undisturbed run.
- R9: After completion, the control and gate words hold their final values until the next start. A new start restarts the walk from R2.
- R10: The L1 reset disable bit (bit 2) and the clock gate bit (bit 6) of the control word stay low at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launches the power-up walk when idle |
| busy | output | 1 | High while the walk is in progress |
| done | output | 1 | One-cycle pulse when the powered-up bit sets |
| pwr_ctl | output | 8 | Power control word (clamp, memory clamp, L1 reset disable, memory head-switch, core reset, power-on reset, clock gate, powered-up in bits 0..7) |
| gate_ctl | output | 32 | Head-switch gate word: enable in bit 0, ramp count in bits 31:24 |

## Verification
The bench builds the block with CYCLES_PER_US = 3 and SETTLE_US = 2, so each settle wait lasts six cycles. A full walk then finishes in about two dozen cycles, and many runs fit easily. This makes it possible to check the exact cycle of every step, to restart repeatedly from the powered-up state, and to place random ignored start pulses and reset hits in every phase of the walk. RAMP_COUNT keeps its default of 16, so the gate word is checked against its intended value.

// File: rtl/cpu_pwrup_pkg.sv
package cpu_pwrup_pkg;

    localparam int CTL_W     = 8;
    localparam int GATE_W    = 32;
    localparam int RAMP_W    = 8;
    localparam int RAMP_LSB  = 24;
    localparam int GATE_EN_B = 0;

    // Control word, MSB first so that field i sits at bit i
    typedef struct packed {
        logic pwrd_up;     // 7
        logic clk_gate;    // 6
        logic por_rst;     // 5
        logic core_rst;    // 4
        logic mem_hs;      // 3
        logic l1_rst_dis;  // 2
        logic mem_clamp;   // 1
        logic clamp;       // 0
    } ctl_word_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GATE,
        ST_WAIT_MEM,
        ST_MEM_HS,
        ST_WAIT_CLAMP,
        ST_WAIT_RST,
        ST_PWRUP
    } seq_state_e;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_ENTER,
        CMD_GATE_ON,
        CMD_MEMCLAMP_OFF,
        CMD_MEMHS_ON,
        CMD_CLAMP_OFF,
        CMD_RST_OFF,
        CMD_PWRUP
    } step_cmd_e;

    function automatic ctl_word_t apply_cmd(input ctl_word_t cur, input step_cmd_e cmd);
        ctl_word_t nxt;
        nxt = cur;
        case (cmd)
            CMD_ENTER: begin
                nxt           = '0;
                nxt.clamp     = 1'b1;
                nxt.mem_clamp = 1'b1;
                nxt.core_rst  = 1'b1;
                nxt.por_rst   = 1'b1;
            end
            CMD_MEMCLAMP_OFF: nxt.mem_clamp = 1'b0;
            CMD_MEMHS_ON:     nxt.mem_hs    = 1'b1;
            CMD_CLAMP_OFF:    nxt.clamp     = 1'b0;
            CMD_RST_OFF: begin
                nxt.core_rst = 1'b0;
                nxt.por_rst  = 1'b0;
            end
            CMD_PWRUP:        nxt.pwrd_up   = 1'b1;
            default:          nxt = cur;
        endcase
        return nxt;
    endfunction

    function automatic logic [GATE_W-1:0] make_gate_word(input logic [RAMP_W-1:0] ramp);
        logic [GATE_W-1:0] w;
        w = '0;
        w[RAMP_LSB +: RAMP_W] = ramp;
        w[GATE_EN_B]          = 1'b1;
        return w;
    endfunction

endpackage

// File: rtl/pwrup_settle_timer.sv
module pwrup_settle_timer #(
    parameter int CYCLES_PER_US = 19,
    parameter int SETTLE_US     = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int WAIT_CYC = CYCLES_PER_US * SETTLE_US;
    localparam int CNT_W    = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;

    generate
        if (WAIT_CYC <= 1) begin : g_single
            // one-cycle wait: expires on every running cycle
            assign expired = run;
        end else begin : g_count
            localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT_CYC - 1);
            logic [CNT_W-1:0] cnt_q;

            always_ff @(posedge clk) begin
                if (rst || !run || (cnt_q == LAST)) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end

            assign expired = run && (cnt_q == LAST);
        end
    endgenerate

endmodule

// File: rtl/pwrup_step_fsm.sv
module pwrup_step_fsm
    import cpu_pwrup_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      wait_done,
    output step_cmd_e cmd,
    output logic      wait_run,
    output logic      busy
);
    seq_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        cmd      = CMD_NONE;
        wait_run = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (start) begin
                    cmd     = CMD_ENTER;
                    state_d = ST_GATE;
                end
            end
            ST_GATE: begin
                cmd     = CMD_GATE_ON;
                state_d = ST_WAIT_MEM;
            end
            ST_WAIT_MEM: begin
                wait_run = 1'b1;
                if (wait_done) begin
                    cmd     = CMD_MEMCLAMP_OFF;
                    state_d = ST_MEM_HS;
                end
            end
            ST_MEM_HS: begin
                cmd     = CMD_MEMHS_ON;
                state_d = ST_WAIT_CLAMP;
            end
            ST_WAIT_CLAMP: begin
                wait_run = 1'b1;
                if (wait_done) begin
                    cmd     = CMD_CLAMP_OFF;
                    state_d = ST_WAIT_RST;
                end
            end
            ST_WAIT_RST: begin
                wait_run = 1'b1;
                if (wait_done) begin
                    cmd     = CMD_RST_OFF;
                    state_d = ST_PWRUP;
                end
            end
            ST_PWRUP: begin
                cmd     = CMD_PWRUP;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign busy = (state_q != ST_IDLE);

endmodule

// File: rtl/pwrup_ctl_regs.sv
module pwrup_ctl_regs
    import cpu_pwrup_pkg::*;
#(
    parameter int RAMP_COUNT = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  step_cmd_e         cmd,
    output ctl_word_t         ctl,
    output logic [GATE_W-1:0] gate,
    output logic              done
);
    localparam logic [RAMP_W-1:0] RAMP_VAL = RAMP_W'(RAMP_COUNT);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl  <= '0;
            gate <= '0;
            done <= 1'b0;
        end else begin
            ctl  <= apply_cmd(ctl, cmd);
            done <= (cmd == CMD_PWRUP);
            if (cmd == CMD_ENTER) begin
                gate <= '0;
            end else if (cmd == CMD_GATE_ON) begin
                gate <= make_gate_word(RAMP_VAL);
            end
        end
    end

endmodule

// File: rtl/cpu_pwrup_seq.sv
module cpu_pwrup_seq
    import cpu_pwrup_pkg::*;
#(
    parameter int CYCLES_PER_US = 19,
    parameter int SETTLE_US     = 2,
    parameter int RAMP_COUNT    = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    output logic        busy,
    output logic        done,
    output logic [7:0]  pwr_ctl,
    output logic [31:0] gate_ctl
);
    step_cmd_e step_cmd;
    logic      wait_run;
    logic      wait_done;
    ctl_word_t ctl_q;

    pwrup_step_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .wait_done (wait_done),
        .cmd       (step_cmd),
        .wait_run  (wait_run),
        .busy      (busy)
    );

    pwrup_settle_timer #(
        .CYCLES_PER_US (CYCLES_PER_US),
        .SETTLE_US     (SETTLE_US)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (wait_run),
        .expired (wait_done)
    );

    pwrup_ctl_regs #(
        .RAMP_COUNT (RAMP_COUNT)
    ) u_regs (
        .clk  (clk),
        .rst  (rst),
        .cmd  (step_cmd),
        .ctl  (ctl_q),
        .gate (gate_ctl),
        .done (done)
    );

    assign pwr_ctl = ctl_q;

endmodule

// File: rtl/cpu_pwrup_seq_chk.sv
module cpu_pwrup_seq_chk #(
    parameter int RAMP_COUNT = 16
) (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        busy,
    input logic        done,
    input logic [7:0]  pwr_ctl,
    input logic [31:0] gate_ctl
);
    localparam logic [31:0] GATE_EXP = {8'(RAMP_COUNT), 23'd0, 1'b1};

    assert_enter_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (pwr_ctl == 8'h33) && (gate_ctl == 32'd0));

    assert_gate_with_memhs_R3: assert property (@(posedge clk) disable iff (rst)
        pwr_ctl[3] |-> (gate_ctl == GATE_EXP));

    assert_memclamp_before_hs_R4: assert property (@(posedge clk) disable iff (rst)
        pwr_ctl[3] |-> !pwr_ctl[1]);

    assert_resets_together_R6: assert property (@(posedge clk) disable iff (rst)
        pwr_ctl[4] == pwr_ctl[5]);

    assert_pwrup_last_R7: assert property (@(posedge clk) disable iff (rst)
        pwr_ctl[7] |-> !pwr_ctl[4] && !pwr_ctl[5] && !pwr_ctl[0] && pwr_ctl[3]);

    assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> pwr_ctl[7] && !busy);

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(pwr_ctl) && $stable(gate_ctl));

    assert_spare_low_R10: assert property (@(posedge clk) disable iff (rst)
        !pwr_ctl[2] && !pwr_ctl[6]);

endmodule

bind cpu_pwrup_seq cpu_pwrup_seq_chk #(.RAMP_COUNT(RAMP_COUNT)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .pwr_ctl  (pwr_ctl),
    .gate_ctl (gate_ctl)
);

// File: tb/cpu_pwrup_seq_bench.sv
module cpu_pwrup_seq_bench;

    localparam int CPU    = 3;
    localparam int SET_US = 2;
    localparam int RAMP   = 16;
    localparam int W      = CPU * SET_US;
    localparam int K_DONE = 3 + 3 * W;
    localparam int K_END  = K_DONE + 1;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic        busy;
    logic        done;
    logic [7:0]  pwr_ctl;
    logic [31:0] gate_ctl;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    cpu_pwrup_seq #(
        .CYCLES_PER_US (CPU),
        .SETTLE_US     (SET_US),
        .RAMP_COUNT    (RAMP)
    ) u_cpu_pwrup_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .busy     (busy),
        .done     (done),
        .pwr_ctl  (pwr_ctl),
        .gate_ctl (gate_ctl)
    );

    function automatic logic [7:0] exp_ctl(input int k);
        if (k < 1 + W)      return 8'h33;
        if (k < 2 + W)      return 8'h31;
        if (k < 2 + 2 * W)  return 8'h39;
        if (k < 2 + 3 * W)  return 8'h38;
        if (k < K_DONE)     return 8'h08;
        return 8'h88;
    endfunction

    function automatic logic [31:0] exp_gate(input int k);
        if (k == 0) return 32'd0;
        return (32'(RAMP) << 24) | 32'd1;
    endfunction

    function automatic string tag_of(input int k, input bit inj);
        if (inj)             return "R8";
        if (k == 0)          return "R2";
        if (k < 1 + W)       return "R3";
        if (k < 2 + 2 * W)   return "R4";
        if (k < 2 + 3 * W)   return "R5";
        if (k < K_DONE)      return "R6";
        if (k == K_DONE)     return "R7";
        return "R9";
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_reset_state(input string req);
        chk(req, "pwr_ctl", {24'd0, pwr_ctl}, 32'd0);
        chk(req, "gate_ctl", gate_ctl, 32'd0);
        chk(req, "done", {31'd0, done}, 32'd0);
        chk(req, "busy", {31'd0, busy}, 32'd0);
    endtask

    task automatic run_seq(input bit inject);
        string t;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k <= K_END; k++) begin
            t = tag_of(k, inject);
            chk(t, "pwr_ctl", {24'd0, pwr_ctl}, {24'd0, exp_ctl(k)});
            chk(t, "gate_ctl", gate_ctl, exp_gate(k));
            chk((k == K_DONE) ? "R7" : t, "done", {31'd0, done}, {31'd0, k == K_DONE});
            chk((k == K_DONE) ? "R7" : t, "busy", {31'd0, busy}, {31'd0, k < K_DONE});
            chk("R10", "spare bits", {30'd0, pwr_ctl[6], pwr_ctl[2]}, 32'd0);
            if (inject && k <= K_DONE - 1 && ($urandom % 3 == 0)) start = 1'b1;
            else start = 1'b0;
            @(negedge clk);
        end
        start = 1'b0;
    endtask

    task automatic idle_hold(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk("R9", "held pwr_ctl", {24'd0, pwr_ctl}, 32'h88);
            chk("R9", "held gate_ctl", gate_ctl, exp_gate(1));
        end
    endtask

    task automatic reset_mid(input int at_k);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < at_k; k++) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk_reset_state("R1");
    endtask

    initial begin
        int cyc = 0;
        while (!finished) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                bad++;
                total++;
                $display("FAIL watchdog actual=%0d expected<=100000", cyc);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst   = 1'b1;
        start = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk_reset_state("R1");

        // idle with no start: nothing moves
        repeat (4) @(negedge clk);
        chk_reset_state("R1");

        // directed first run from reset state
        run_seq(1'b0);
        idle_hold(3);

        // restart from powered-up state
        run_seq(1'b0);

        // random runs, some with ignored start pulses while busy
        for (int r = 0; r < 12; r++) begin
            int gap;
            gap = $urandom % 5;
            if (gap > 0) idle_hold(gap);
            run_seq(($urandom % 2) == 1);
        end

        // reset hits at each phase of the walk
        reset_mid(0);
        reset_mid(W);
        reset_mid(2 + W);
        reset_mid(2 + 2 * W);
        reset_mid(K_DONE - 1);
        for (int r = 0; r < 4; r++) reset_mid($urandom % K_DONE);

        // a full run after reset hits
        run_seq(1'b1);
        idle_hold(2);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule